// File: doc/BRIEF.md
# Saturating Pulse Position Counter

This block keeps a signed position count for a pulse-train output port. Every pulse that the port emits moves the count by one step, upward when the forward direction is selected and downward otherwise. At either end of the signed range the count stops and holds; it never wraps.

The count can be set to a given value by a load strobe. This strobe is used at power-up and at operation start, and it can load any value. When relative coordinates are selected, the count also returns to zero at the start of each motion. When absolute coordinates are selected, a motion start does not change the count. The count is presented as an upper and a lower half-word. Pulse generation takes place elsewhere. Each strobe is a single-cycle input, sampled on the rising clock edge. Every effect of a strobe shows at the outputs after that same edge.

Top module: `pulse_pos_counter`

## Requirements
- R1: While reset is active (rst_n low), and after reset is released, both output words read 0 until the first pulse, start or load is sampled.
- R2: A sampled pulse with dir_fwd=1 adds 1 to the count. A sampled pulse with dir_fwd=0 subtracts 1. A cycle with no pulse, no start and no load leaves the count unchanged.
- R3: A forward pulse when the count is 0x7FFFFFFF leaves it at 0x7FFFFFFF.
- R4: A reverse pulse when the count is 0x80000000 leaves it at 0x80000000.
- R5: A sampled start with rel_mode=1 sets the count to 0, even if a pulse is sampled in the same cycle.
- R6: A sampled load sets the count to load_val. It overrides any start or pulse sampled in the same cycle.
- R7: A sampled start with rel_mode=0 has no effect on the count. A pulse sampled in the same cycle is applied as described in R2.
- R8: pos_hi carries count bits 31:16 and pos_lo carries bits 15:0. Both update on the clock edge that samples the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse | input | 1 | One emitted pulse per high cycle |
| dir_fwd | input | 1 | 1 = forward (count up), 0 = reverse (count down) |
| start | input | 1 | Motion-start strobe |
| rel_mode | input | 1 | 1 = relative coordinates, 0 = absolute |
| load | input | 1 | Load strobe |
| load_val | input | 32 | Value written by load |
| pos_hi | output | 16 | Count bits 31:16 |
| pos_lo | output | 16 | Count bits 15:0 |

## Verification
The assertions assume that every control input is a known value at each sampled edge. They also assume that at most one action takes effect per cycle, with load first, then the relative-mode start clear, then the pulse. The stimulus drives each input on the falling edge and holds it for a full period, so every value is stable at the rising edge. The bench first loads a base value next to each signed limit, at zero and at minus one. From each base it applies all 32 combinations of pulse, direction, start, mode and load, and compares the result with an arithmetic model that saturates at the limits.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_CLEAR = 2'd2,
        ACT_STEP  = 2'd3
    } ppc_action_e;
endpackage

// File: rtl/ppc_arbiter.sv
module ppc_arbiter
    import ppc_pkg::*;
(
    input  logic        pulse,
    input  logic        start,
    input  logic        rel_mode,
    input  logic        load,
    output ppc_action_e action
);
    // Priority: load, then relative-mode clear, then pulse step.
    always_comb begin
        if (load)
            action = ACT_LOAD;
        else if (start && rel_mode)
            action = ACT_CLEAR;
        else if (pulse)
            action = ACT_STEP;
        else
            action = ACT_HOLD;
    end
endmodule

// File: rtl/ppc_sat_step.sv
module ppc_sat_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] POS_MIN = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        if (up)
            nxt = (cur == POS_MAX) ? cur : cur + 1'b1;
        else
            nxt = (cur == POS_MIN) ? cur : cur - 1'b1;
    end
endmodule

// File: rtl/ppc_word_split.sv
module ppc_word_split #(
    parameter int WORD_W = 16,
    parameter int NWORDS = 2
) (
    input  logic [WORD_W*NWORDS-1:0]        value,
    output logic [NWORDS-1:0][WORD_W-1:0]   words
);
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        assign words[g] = value[g*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/pulse_pos_counter.sv
module pulse_pos_counter
    import ppc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pulse,
    input  logic                dir_fwd,
    input  logic                start,
    input  logic                rel_mode,
    input  logic                load,
    input  logic [2*WORD_W-1:0] load_val,
    output logic [WORD_W-1:0]   pos_hi,
    output logic [WORD_W-1:0]   pos_lo
);
    localparam int NWORDS = 2;
    localparam int WIDTH  = NWORDS * WORD_W;
    localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] POS_MIN = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] pos;
    } ppc_state_t;

    ppc_state_t  st_d, st_q;
    ppc_action_e action;
    logic [WIDTH-1:0] step_val;
    logic [NWORDS-1:0][WORD_W-1:0] words;

    ppc_arbiter u_arb (
        .pulse    (pulse),
        .start    (start),
        .rel_mode (rel_mode),
        .load     (load),
        .action   (action)
    );

    ppc_sat_step #(.WIDTH(WIDTH)) u_step (
        .cur (st_q.pos),
        .up  (dir_fwd),
        .nxt (step_val)
    );

    always_comb begin
        st_d = st_q;
        unique case (action)
            ACT_LOAD:  st_d.pos = load_val;
            ACT_CLEAR: st_d.pos = '0;
            ACT_STEP:  st_d.pos = step_val;
            default:   st_d.pos = st_q.pos;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    ppc_word_split #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_split (
        .value (st_q.pos),
        .words (words)
    );

    assign pos_hi = words[1];
    assign pos_lo = words[0];

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (st_q.pos == '0));                                                   // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && !start && !load) |=> $stable(st_q.pos));                             // R2
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && dir_fwd && !load && !(start && rel_mode) && st_q.pos != POS_MAX)
        |=> (st_q.pos == $past(st_q.pos) + 1'b1));                                      // R2
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !dir_fwd && !load && !(start && rel_mode) && st_q.pos != POS_MIN)
        |=> (st_q.pos == $past(st_q.pos) - 1'b1));                                      // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && dir_fwd && !load && !(start && rel_mode) && st_q.pos == POS_MAX)
        |=> (st_q.pos == POS_MAX));                                                     // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !dir_fwd && !load && !(start && rel_mode) && st_q.pos == POS_MIN)
        |=> (st_q.pos == POS_MIN));                                                     // R4
    AST_REL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rel_mode && !load) |=> (st_q.pos == '0));                             // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.pos == $past(load_val)));                                        // R6
    AST_ABS_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !rel_mode && !load && !pulse) |=> $stable(st_q.pos));                 // R7
    AST_WORD_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        ({pos_hi, pos_lo} == st_q.pos));                                                // R8
endmodule

// File: tb/pulse_pos_counter_tb.sv
module pulse_pos_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse = 1'b0, dir_fwd = 1'b0, start = 1'b0, rel_mode = 1'b0, load = 1'b0;
    logic [31:0] load_val = '0;
    logic [15:0] pos_hi, pos_lo;

    int checks = 0;
    int failures = 0;
    longint model = 0;
    bit done = 1'b0;

    localparam longint LMAX = 64'sd2147483647;
    localparam longint LMIN = -64'sd2147483648;

    always #10 clk = ~clk;  // 50 MHz

    pulse_pos_counter u_dut (
        .clk(clk), .rst_n(rst_n), .pulse(pulse), .dir_fwd(dir_fwd), .start(start),
        .rel_mode(rel_mode), .load(load), .load_val(load_val),
        .pos_hi(pos_hi), .pos_lo(pos_lo)
    );

    task automatic check(input string req);
        logic [31:0] exp;
        exp = model[31:0];
        checks++;
        if ({pos_hi, pos_lo} !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h_%h expected=%h_%h", req, pos_hi, pos_lo, exp[31:16], exp[15:0]);
        end
    endtask

    // Drive on the falling edge, one rising edge updates, check on the next falling edge.
    task automatic apply(input bit p, input bit d, input bit s, input bit r, input bit l,
                         input longint v, input string req);
        @(negedge clk);
        pulse = p; dir_fwd = d; start = s; rel_mode = r; load = l; load_val = v[31:0];
        if (l)             model = v;
        else if (s && r)   model = 0;
        else if (p && d)   model = (model == LMAX) ? LMAX : model + 1;
        else if (p)        model = (model == LMIN) ? LMIN : model - 1;
        @(negedge clk);
        pulse = 0; start = 0; load = 0;
        check(req);
    endtask

    initial begin
        longint bases [4];
        bases[0] = LMAX - 1; bases[1] = LMIN + 1; bases[2] = 0; bases[3] = -1;
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");
        apply(0, 0, 0, 0, 0, 0, "R2 idle");
        // R8 word mapping with distinct halves
        apply(0, 0, 0, 0, 1, 64'h12345678, "R8 load split");
        apply(1, 1, 0, 0, 0, 0, "R8 R2 up");
        apply(0, 0, 0, 0, 1, 64'h0000FFFF, "R8 carry base");
        apply(1, 1, 0, 0, 0, 0, "R8 carry into hi");
        apply(1, 0, 0, 0, 0, 0, "R8 borrow from hi");
        // Sweep all control combinations from bases near each limit, zero and -1
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 32; c++) begin
                apply(0, 0, 0, 0, 1, bases[b], "R6 base load");
                apply(c[0], c[1], c[2], c[3], c[4], 64'sd1000 + c,
                      c[4] ? "R6 load priority" :
                      (c[2] && c[3]) ? "R5 rel clear" :
                      c[2] ? "R7 abs start" : "R2 step");
                // a second step from the result crosses the limits
                apply(c[0], c[1], 0, 0, 0, 0, "R3 R4 R2 follow-on");
            end
        end
        // Long saturating runs
        apply(0, 0, 0, 0, 1, LMAX - 2, "R6 load");
        for (int i = 0; i < 5; i++) apply(1, 1, 0, 0, 0, 0, "R3 saturate high");
        apply(1, 0, 0, 0, 0, 0, "R2 leave max");
        apply(0, 0, 0, 0, 1, LMIN + 2, "R6 load");
        for (int i = 0; i < 5; i++) apply(1, 0, 0, 1, 0, 0, "R4 saturate low");
        apply(1, 1, 1, 0, 0, 0, "R7 abs start with pulse");
        apply(1, 1, 1, 1, 0, 0, "R5 rel start with pulse");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule